// File: doc/BRIEF.md
# Guard-Round-Sticky Rounding Unit

This block is the final rounding step of a floating-point result path. It takes an unpacked mantissa with two extra bits at the bottom, plus a separate sticky bit, the operand sign and a two-bit rounding-mode selector. The extra bits are the guard bit (upper) and the round bit (lower). It drops the two extra bits, decides from the mode whether the discarded part forces an increment, and applies that increment with full carry. The result is one bit wider than the shifted mantissa, so a carry out of the top stays visible to the consumer. That consumer renormalises and adjusts the exponent.

The same mode field drives a second, independent decision used on exponent overflow. It says whether an overflowing result becomes infinity or the largest finite magnitude of the operand's sign. The block is purely combinational. It has no exponent handling and no packing into a storage format.

Top module: `rnd_grs_top`

## Requirements
- R1: When guard, round and sticky are all 0, `mantOut` equals `mantIn` shifted right by two, and both `inexact` and `roundedUp` are 0.
- R2: `inexact` is 1 exactly when at least one of guard (`mantIn[1]`), round (`mantIn[0]`) or `stickyIn` is 1, in every rounding mode.
- R3: With `modeIn` = 00 (nearest, ties to even), `roundedUp` is 1 exactly when guard is 1 and at least one of these is 1: round, sticky, or the shifted LSB (`mantIn[2]`).
- R4: With `modeIn` = 01 (toward zero), `roundedUp` is always 0.
- R5: With `modeIn` = 10 (toward plus infinity), `roundedUp` is 1 exactly when `inexact` is 1 and `signIn` is 0.
- R6: With `modeIn` = 11 (toward minus infinity), `roundedUp` is 1 exactly when `inexact` is 1 and `signIn` is 1.
- R7: `mantOut` equals the shifted mantissa, zero-extended by one bit, plus `roundedUp`. A carry out of the shifted field lands in the top bit of `mantOut`.
- R8: `ovfToInf` is 1 for mode 00 and 0 for mode 01. It equals the inverse of `signIn` for mode 10 and equals `signIn` for mode 11. It does not depend on the mantissa or sticky inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mantIn | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| stickyIn | input | 1 | OR of all bits below the round bit |
| signIn | input | 1 | Operand sign, 1 = negative |
| modeIn | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| mantOut | output | MANT_W-1 | Shifted and rounded mantissa with carry bit on top |
| inexact | output | 1 | Discarded bits were non-zero |
| roundedUp | output | 1 | An increment was applied |
| ovfToInf | output | 1 | On overflow, return infinity (1) or largest finite value (0) |

## Verification
The checker tests on every input change the properties that hold for any operand. These are the inexact rule, the exact-case pass-through and the relation between `mantOut` and `roundedUp`. They also cover the absence of increments in toward-zero mode, the sign gating of the directed modes and the fixed overflow choices. Only the bench scenarios can show the specific corner cases. These are ties resolving to even for both LSB parities, a carry that runs through an all-ones mantissa into the top bit, and agreement with an independent model across random operands in all modes and signs.

// File: rtl/rnd_grs_pkg.sv
package rnd_grs_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_POSINF  = 2'b10,
    RND_NEGINF  = 2'b11
  } rndMode_t;

  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic bumpLsb;
    logic lostBits;
  } rndStrobe_t;

endpackage

// File: rtl/rnd_grs_ctrl.sv
module rnd_grs_ctrl
  import rnd_grs_pkg::*;
(
  input  logic       guardBit,
  input  logic       roundBit,
  input  logic       stickyIn,
  input  logic       lsbBit,
  input  logic       signIn,
  input  logic [1:0] modeIn,
  output rndStrobe_t strobe,
  output logic       ovfToInf
);

  rndMode_t mode;
  logic     anyLost;
  logic     nearBump;

  assign mode     = rndMode_t'(modeIn);
  assign anyLost  = guardBit | roundBit | stickyIn;
  // ties (guard only) go up only when the kept LSB is odd
  assign nearBump = guardBit & (roundBit | stickyIn | lsbBit);

  always_comb begin
    strobe.lostBits = anyLost;
    strobe.bumpLsb  = 1'b0;
    ovfToInf        = 1'b1;
    unique case (mode)
      RND_NEAREST: begin
        strobe.bumpLsb = nearBump;
        ovfToInf       = 1'b1;
      end
      RND_ZERO: begin
        strobe.bumpLsb = 1'b0;
        ovfToInf       = 1'b0;
      end
      RND_POSINF: begin
        strobe.bumpLsb = anyLost & ~signIn;
        ovfToInf       = ~signIn;
      end
      RND_NEGINF: begin
        strobe.bumpLsb = anyLost & signIn;
        ovfToInf       = signIn;
      end
      default: begin
        strobe.bumpLsb = 1'b0;
        ovfToInf       = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rnd_grs_dp.sv
module rnd_grs_dp
  import rnd_grs_pkg::*;
#(
  parameter int MANT_W = 28
) (
  input  logic [MANT_W-1:0] mantIn,
  input  rndStrobe_t        strobe,
  output logic [MANT_W-2:0] mantOut
);

  localparam int OUT_W  = MANT_W - 1;
  localparam int KEEP_W = MANT_W - 2;

  logic [OUT_W-1:0] shifted;
  logic [OUT_W-1:0] bump;

  assign shifted = {1'b0, mantIn[MANT_W-1:2]};
  assign bump    = {{(OUT_W-1){1'b0}}, strobe.bumpLsb};
  assign mantOut = shifted + bump;

  // keep the unused strobe visible to lint without a pragma
  logic unusedLost;
  assign unusedLost = strobe.lostBits & (KEEP_W > 0);

endmodule

// File: rtl/rnd_grs_top.sv
module rnd_grs_top
  import rnd_grs_pkg::*;
#(
  parameter int MANT_W = 28
) (
  input  logic [MANT_W-1:0] mantIn,
  input  logic              stickyIn,
  input  logic              signIn,
  input  logic [1:0]        modeIn,
  output logic [MANT_W-2:0] mantOut,
  output logic              inexact,
  output logic              roundedUp,
  output logic              ovfToInf
);

  rndStrobe_t strobe;

  rnd_grs_ctrl u_ctrl (
    .guardBit (mantIn[1]),
    .roundBit (mantIn[0]),
    .stickyIn (stickyIn),
    .lsbBit   (mantIn[2]),
    .signIn   (signIn),
    .modeIn   (modeIn),
    .strobe   (strobe),
    .ovfToInf (ovfToInf)
  );

  rnd_grs_dp #(.MANT_W(MANT_W)) u_dp (
    .mantIn  (mantIn),
    .strobe  (strobe),
    .mantOut (mantOut)
  );

  assign inexact   = strobe.lostBits;
  assign roundedUp = strobe.bumpLsb;

endmodule

// File: rtl/rnd_grs_chk.sv
module rnd_grs_chk #(
  parameter int MANT_W = 28
) (
  input logic [MANT_W-1:0] mantIn,
  input logic              stickyIn,
  input logic              signIn,
  input logic [1:0]        modeIn,
  input logic [MANT_W-2:0] mantOut,
  input logic              inexact,
  input logic              roundedUp,
  input logic              ovfToInf
);

  logic [MANT_W-2:0] plainShift;
  assign plainShift = {1'b0, mantIn[MANT_W-1:2]};

  always_comb begin
    AST_EXACT_PASS: assert (inexact || (!roundedUp && mantOut == plainShift)) else $error("exact pass"); // R1
    AST_INEXACT_SRC: assert (inexact == (mantIn[1] | mantIn[0] | stickyIn)) else $error("inexact"); // R2
    AST_NEAR_NO_BUMP: assert (!(modeIn == 2'b00 && !mantIn[1]) || !roundedUp) else $error("nearest"); // R3
    AST_ZERO_NO_BUMP: assert (modeIn != 2'b01 || !roundedUp) else $error("toward zero"); // R4
    AST_POS_SIGN: assert (!(modeIn == 2'b10 && signIn) || !roundedUp) else $error("plus inf"); // R5
    AST_NEG_SIGN: assert (!(modeIn == 2'b11 && !signIn) || !roundedUp) else $error("minus inf"); // R6
    AST_SUM_OUT: assert (mantOut == plainShift + {{(MANT_W-2){1'b0}}, roundedUp}) else $error("sum"); // R7
    AST_OVF_NEAR: assert (modeIn != 2'b00 || ovfToInf) else $error("ovf nearest"); // R8
    AST_OVF_ZERO: assert (modeIn != 2'b01 || !ovfToInf) else $error("ovf zero"); // R8
  end

endmodule

bind rnd_grs_top rnd_grs_chk #(.MANT_W(MANT_W)) u_chk (
  .mantIn    (mantIn),
  .stickyIn  (stickyIn),
  .signIn    (signIn),
  .modeIn    (modeIn),
  .mantOut   (mantOut),
  .inexact   (inexact),
  .roundedUp (roundedUp),
  .ovfToInf  (ovfToInf)
);

// File: tb/tb_rnd_grs_top.sv
module tb_rnd_grs_top;

  localparam int MW = 28;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [MW-1:0] mantIn = '0;
  logic          stickyIn = 1'b0;
  logic          signIn = 1'b0;
  logic [1:0]    modeIn = 2'b00;
  logic [MW-2:0] mantOut;
  logic          inexact, roundedUp, ovfToInf;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  rnd_grs_top #(.MANT_W(MW)) dut (
    .mantIn(mantIn), .stickyIn(stickyIn), .signIn(signIn), .modeIn(modeIn),
    .mantOut(mantOut), .inexact(inexact), .roundedUp(roundedUp), .ovfToInf(ovfToInf)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [MW-1:0] m, input logic s, input logic sg, input logic [1:0] md);
    @(negedge clk);
    mantIn = m; stickyIn = s; signIn = sg; modeIn = md;
    #2;
  endtask

  // independent model from the requirement text
  task automatic model(output longint eOut, output bit eInx, output bit eUp, output bit eInf);
    bit g, r, l;
    g = mantIn[1]; r = mantIn[0]; l = mantIn[2];
    eInx = g | r | stickyIn;
    case (modeIn)
      2'b00: begin eUp = g & (r | stickyIn | l); eInf = 1'b1; end
      2'b01: begin eUp = 1'b0; eInf = 1'b0; end
      2'b10: begin eUp = eInx & !signIn; eInf = !signIn; end
      default: begin eUp = eInx & signIn; eInf = signIn; end
    endcase
    eOut = longint'(mantIn >> 2) + longint'(eUp);
  endtask

  task automatic checkAll(input string req);
    longint eOut; bit eInx, eUp, eInf;
    model(eOut, eInx, eUp, eInf);
    check(longint'(mantOut) == eOut, {req, " mantOut R7"}, longint'(mantOut), eOut);
    check(inexact == eInx, {req, " inexact R2"}, longint'(inexact), longint'(eInx));
    check(roundedUp == eUp, {req, " roundedUp"}, longint'(roundedUp), longint'(eUp));
    check(ovfToInf == eInf, {req, " ovfToInf R8"}, longint'(ovfToInf), longint'(eInf));
  endtask

  task automatic t_reset;
    #2;
    check(mantOut == '0, "reset mantOut R1", longint'(mantOut), 0);
    check(!inexact && !roundedUp, "reset flags R1", longint'({inexact, roundedUp}), 0);
    check(ovfToInf, "reset ovfToInf R8", longint'(ovfToInf), 1);
  endtask

  task automatic t_exact;
    for (int md = 0; md < 4; md++) begin
      apply(28'h5A5_A5A4, 1'b0, md[0], md[1:0]);
      check(mantOut == 27'h169_6969, "exact shift R1", longint'(mantOut), 64'h1696969);
      check(!inexact && !roundedUp, "exact flags R1", longint'({inexact, roundedUp}), 0);
    end
  endtask

  task automatic t_ties;
    apply(28'h000_0012, 1'b0, 1'b0, 2'b00);
    check(!roundedUp && mantOut == 27'h4, "tie even stays R3", longint'(mantOut), 4);
    apply(28'h000_0016, 1'b0, 1'b0, 2'b00);
    check(roundedUp && mantOut == 27'h6, "tie odd goes up R3", longint'(mantOut), 6);
    apply(28'h000_0011, 1'b0, 1'b1, 2'b00);
    check(!roundedUp && inexact, "below half R3", longint'(roundedUp), 0);
    apply(28'h000_0012, 1'b1, 1'b0, 2'b00);
    check(roundedUp && mantOut == 27'h5, "above half via sticky R3", longint'(mantOut), 5);
  endtask

  task automatic t_directed;
    apply(28'h000_0013, 1'b1, 1'b0, 2'b01);
    check(!roundedUp && mantOut == 27'h4 && inexact, "toward zero R4", longint'(mantOut), 4);
    apply(28'h000_0011, 1'b0, 1'b0, 2'b10);
    check(roundedUp && mantOut == 27'h5, "plus inf positive R5", longint'(mantOut), 5);
    apply(28'h000_0011, 1'b0, 1'b1, 2'b10);
    check(!roundedUp && mantOut == 27'h4, "plus inf negative R5", longint'(mantOut), 4);
    apply(28'h000_0010, 1'b1, 1'b1, 2'b11);
    check(roundedUp && mantOut == 27'h5, "minus inf negative R6", longint'(mantOut), 5);
    apply(28'h000_0010, 1'b1, 1'b0, 2'b11);
    check(!roundedUp && mantOut == 27'h4, "minus inf positive R6", longint'(mantOut), 4);
    apply(28'h000_0010, 1'b0, 1'b1, 2'b11);
    check(!roundedUp && !inexact, "minus inf exact R6", longint'(roundedUp), 0);
  endtask

  task automatic t_carry;
    apply({{(MW-2){1'b1}}, 2'b11}, 1'b0, 1'b0, 2'b00);
    check(mantOut == {1'b1, {(MW-2){1'b0}}}, "carry into top bit R7",
          longint'(mantOut), longint'(1) << (MW-2));
  endtask

  task automatic t_ovf;
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++) begin
        apply(28'hFFF_FFFF, 1'b1, sg[0], md[1:0]);
        checkAll("ovf choice R8");
      end
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [MW-1:0] m;
      m = MW'($urandom);
      if (i % 8 == 0) m[1:0] = 2'b10;
      apply(m, (i % 8 == 0) ? 1'b0 : 1'($urandom), 1'($urandom), 2'(i));
      checkAll("random R3 R4 R5 R6");
    end
  endtask

  initial begin
    #100000000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    t_reset();
    rstN = 1'b1;
    t_exact();
    t_ties();
    t_directed();
    t_carry();
    t_ovf();
    t_random();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule